// File: doc/BRIEF.md
# Indirect Register Write Record Sequencer

This block sits on the configuration byte stream that a boot-time loader reads out of serial memory. Bytes that the loader flags as belonging to the indirect-write region are packed into fixed seven-byte records. Each complete record is replayed as seven byte writes into an indirect-access window. The window has four data registers, an address-low register, an address-high register and a command register. The write to the command register is what launches the 32-bit transfer into the target register file behind the window.

A record carries its 32-bit data least significant byte first, then the 16-bit target address low byte first, then one command byte. For example, the stream `0C 00 18 10 00 00 01` stores `0x1018000C` at indirect address `0x0000`. The first port's records cover control, MII data, MII address and flow control. Every further port carries only control and flow control. The block does not care which record is which: it replays them in stream order.

After a command write the block waits for the target's completion acknowledge before it touches the window again. A record that is cut short at the end of the stream is dropped and flagged. The block reports completion only once the last record's transfer has been acknowledged.

Top module: `irs_seq`

State machines. The collector has two states: `COL_FILL` gathers bytes, and `COL_FULL` holds a complete record until the issuer takes it. The transitions are FILL→FULL on the seventh byte, FULL→FILL on take, and FILL→FILL with a drop when the stream ends mid-record. The issuer has four states, walked in this order: `ISS_IDLE` → `ISS_DATA` (window registers 0 to 5) → `ISS_CMD` (register 6) → `ISS_WAIT` → back to `ISS_IDLE` on acknowledge. The top-level phase machine runs `PH_RUN` → `PH_DRAIN` on `stream_end`, then `PH_DRAIN` → `PH_DONE` once the collector is empty and the issuer is idle.

## Requirements
- R1: After reset, `win_we`, `xfer_busy`, `done` and `err_partial` are 0 and `in_ready` is 1.
- R2: A byte is taken into a record only when `in_valid` and `in_rec_region` are both 1 and `in_ready` is 1. Any other byte does not advance the record and causes no window write.
- R3: Record byte k (k = 0..6) is written to window select k. Selects 0 to 3 hold data bytes, least significant first. Select 4 holds the address low byte, select 5 the address high byte, and select 6 the command byte (0x01 = write).
- R4: The command write (select 6) is the last write of a record. `xfer_busy` is 1 in the following cycle and stays 1 until the cycle after `tgt_ack` is sampled high.
- R5: A record's seven window writes occur on seven consecutive cycles with selects 0,1,2,3,4,5,6 in that order.
- R6: No window write occurs while `xfer_busy` is 1. The next record's writes start only after the acknowledge.
- R7: While a complete record waits for the issuer, `in_ready` is 0.
- R8: If `stream_end` arrives with 1 to 6 record bytes collected, those bytes are discarded, no command write is issued for them, and `err_partial` becomes 1 and stays 1 until reset.
- R9: `done` rises only after `stream_end` has been seen and the last complete record's transfer has been acknowledged. It then stays 1 until reset, and no window write or busy period follows.
- R10: Bytes presented after `stream_end` are ignored and cause no window write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte is valid this cycle |
| in_byte | input | BYTE_W | Stream byte |
| in_rec_region | input | 1 | Byte lies in the indirect-write record region |
| in_ready | output | 1 | Record bytes can be accepted this cycle |
| stream_end | input | 1 | One-cycle pulse: the configuration stream has ended |
| win_we | output | 1 | Window register write strobe |
| win_sel | output | SEL_W | Window register select (0..6) |
| win_wdata | output | BYTE_W | Window write data |
| tgt_ack | input | 1 | Target reports that the launched indirect write has completed |
| xfer_busy | output | 1 | An indirect write is outstanding |
| done | output | 1 | All complete records have been transferred |
| err_partial | output | 1 | A truncated record was discarded |

## Verification
The example record shows whether the byte-to-select mapping and the least-significant-first ordering are right. A scoreboard compares the reassembled address, data and command of every launched transfer against what the driver sent. Records are also sent with non-region bytes and idle gaps between them, which shows whether stray bytes can leak into a record. A long acknowledge delay, with the following records already queued, shows that the window stays quiet while busy and that input is held off. The stream is then ended both cleanly and mid-record, which tells the done path apart from the discard path, and bytes sent after the end show that the stream is closed.

// File: rtl/irs_pkg.sv
package irs_pkg;

    typedef enum logic {
        COL_FILL,
        COL_FULL
    } col_state_e;

    typedef enum logic [1:0] {
        ISS_IDLE,
        ISS_DATA,
        ISS_CMD,
        ISS_WAIT
    } iss_state_e;

    typedef enum logic [1:0] {
        PH_RUN,
        PH_DRAIN,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/irs_collector.sv
module irs_collector
    import irs_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int REC_LEN = 7,
    parameter int CNT_W   = $clog2(REC_LEN + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_en,
    input  logic [BYTE_W-1:0]         byte_in,
    input  logic                      stream_end,
    input  logic                      take,
    output logic                      in_ready,
    output logic                      rec_full,
    output logic                      empty,
    output logic                      drop,
    output logic [REC_LEN*BYTE_W-1:0] rec_flat
);
    localparam int                IDX_W    = $clog2(REC_LEN);
    localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(REC_LEN);

    col_state_e        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
    logic              accept;
    logic [BYTE_W-1:0] bytes_q [REC_LEN];

    // next state
    always_comb begin
        accept  = acc_en && (st_q == COL_FILL);
        cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, accept};
        st_d    = st_q;
        cnt_d   = cnt_q;
        drop    = 1'b0;
        unique case (st_q)
            COL_FILL: begin
                if (cnt_inc == FULL_CNT) begin
                    st_d  = COL_FULL;
                    cnt_d = cnt_inc;
                end else if (stream_end && (cnt_inc != '0)) begin
                    cnt_d = '0;
                    drop  = 1'b1;
                end else begin
                    cnt_d = cnt_inc;
                end
            end
            COL_FULL: begin
                if (take) begin
                    st_d  = COL_FILL;
                    cnt_d = '0;
                end
            end
            default: begin
                st_d  = COL_FILL;
                cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= COL_FILL;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            bytes_q[cnt_q[IDX_W-1:0]] <= byte_in;
        end
    end

    // outputs
    always_comb begin
        in_ready = (st_q == COL_FILL);
        rec_full = (st_q == COL_FULL);
        empty    = (st_q == COL_FILL) && (cnt_q == '0);
    end

    for (genvar g = 0; g < REC_LEN; g++) begin : g_flat
        assign rec_flat[g*BYTE_W +: BYTE_W] = bytes_q[g];
    end

endmodule

// File: rtl/irs_issuer.sv
module irs_issuer
    import irs_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int REC_LEN = 7,
    parameter int SEL_W   = $clog2(REC_LEN)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rec_full,
    input  logic [REC_LEN*BYTE_W-1:0] rec_flat,
    input  logic                      tgt_ack,
    output logic                      take,
    output logic                      win_we,
    output logic [SEL_W-1:0]          win_sel,
    output logic [BYTE_W-1:0]         win_wdata,
    output logic                      busy,
    output logic                      idle
);
    localparam logic [SEL_W-1:0] LAST_DATA = SEL_W'(REC_LEN - 2);

    iss_state_e        st_q, st_d;
    logic [SEL_W-1:0]  idx_q, idx_d;
    logic              load;
    logic [BYTE_W-1:0] hold_q [REC_LEN];

    // next state
    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        load  = 1'b0;
        unique case (st_q)
            ISS_IDLE: begin
                if (rec_full) begin
                    st_d  = ISS_DATA;
                    idx_d = '0;
                    load  = 1'b1;
                end
            end
            ISS_DATA: begin
                idx_d = idx_q + SEL_W'(1);
                if (idx_q == LAST_DATA) begin
                    st_d = ISS_CMD;
                end
            end
            ISS_CMD: begin
                st_d = ISS_WAIT;
            end
            ISS_WAIT: begin
                if (tgt_ack) begin
                    st_d = ISS_IDLE;
                end
            end
            default: begin
                st_d  = ISS_IDLE;
                idx_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ISS_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < REC_LEN; i++) begin
                hold_q[i] <= rec_flat[i*BYTE_W +: BYTE_W];
            end
        end
    end

    // outputs
    always_comb begin
        take      = (st_q == ISS_IDLE) && rec_full;
        win_we    = (st_q == ISS_DATA) || (st_q == ISS_CMD);
        win_sel   = idx_q;
        win_wdata = hold_q[idx_q];
        busy      = (st_q == ISS_WAIT);
        idle      = (st_q == ISS_IDLE);
    end

endmodule

// File: rtl/irs_seq.sv
module irs_seq
    import irs_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int DATA_BYTES = 4,
    parameter int ADDR_BYTES = 2,
    parameter int SEL_W      = $clog2(DATA_BYTES + ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_rec_region,
    output logic              in_ready,
    input  logic              stream_end,
    output logic              win_we,
    output logic [SEL_W-1:0]  win_sel,
    output logic [BYTE_W-1:0] win_wdata,
    input  logic              tgt_ack,
    output logic              xfer_busy,
    output logic              done,
    output logic              err_partial
);
    localparam int REC_LEN = DATA_BYTES + ADDR_BYTES + 1;

    phase_e                    ph_q, ph_d;
    logic                      err_q;
    logic                      acc_en, take, rec_full, coll_empty, drop, iss_idle;
    logic [REC_LEN*BYTE_W-1:0] rec_flat;

    assign acc_en = in_valid && in_rec_region && (ph_q == PH_RUN);

    irs_collector #(
        .BYTE_W (BYTE_W),
        .REC_LEN(REC_LEN)
    ) u_collector (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .byte_in   (in_byte),
        .stream_end(stream_end && (ph_q == PH_RUN)),
        .take      (take),
        .in_ready  (in_ready),
        .rec_full  (rec_full),
        .empty     (coll_empty),
        .drop      (drop),
        .rec_flat  (rec_flat)
    );

    irs_issuer #(
        .BYTE_W (BYTE_W),
        .REC_LEN(REC_LEN),
        .SEL_W  (SEL_W)
    ) u_issuer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rec_full (rec_full),
        .rec_flat (rec_flat),
        .tgt_ack  (tgt_ack),
        .take     (take),
        .win_we   (win_we),
        .win_sel  (win_sel),
        .win_wdata(win_wdata),
        .busy     (xfer_busy),
        .idle     (iss_idle)
    );

    // phase next state
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_RUN:   if (stream_end) ph_d = PH_DRAIN;
            PH_DRAIN: if (coll_empty && iss_idle) ph_d = PH_DONE;
            PH_DONE:  ph_d = PH_DONE;
            default:  ph_d = PH_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= PH_RUN;
            err_q <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            err_q <= err_q || drop;
        end
    end

    // outputs
    always_comb begin
        done        = (ph_q == PH_DONE);
        err_partial = err_q;
    end

endmodule

// File: rtl/irs_checker.sv
module irs_checker #(
    parameter int SEL_W   = 3,
    parameter int REC_LEN = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             win_we,
    input logic [SEL_W-1:0] win_sel,
    input logic             tgt_ack,
    input logic             xfer_busy,
    input logic             done,
    input logic             err_partial
);
    localparam logic [SEL_W-1:0] CMD_SEL = SEL_W'(REC_LEN - 1);

    AST_CMD_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && win_sel == CMD_SEL) |=> xfer_busy); // R4

    AST_BUSY_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && !tgt_ack) |=> xfer_busy); // R4

    AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && win_sel != CMD_SEL) |=> (win_we && win_sel == $past(win_sel) + SEL_W'(1))); // R5

    AST_FIRST_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_we) |-> (win_sel == '0)); // R5

    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |-> !win_we); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_partial |=> err_partial); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R9

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!xfer_busy && !win_we)); // R9

endmodule

bind irs_seq irs_checker #(
    .SEL_W  (SEL_W),
    .REC_LEN(DATA_BYTES + ADDR_BYTES + 1)
) u_irs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_we     (win_we),
    .win_sel    (win_sel),
    .tgt_ack    (tgt_ack),
    .xfer_busy  (xfer_busy),
    .done       (done),
    .err_partial(err_partial)
);

// File: tb/irs_seq_bench.sv
module irs_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_rec_region = 1'b0;
    logic       in_ready;
    logic       stream_end = 1'b0;
    logic       win_we;
    logic [2:0] win_sel;
    logic [7:0] win_wdata;
    logic       tgt_ack = 1'b0;
    logic       xfer_busy;
    logic       done;
    logic       err_partial;

    always #2.5 clk = ~clk;

    irs_seq u_irs_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .in_rec_region(in_rec_region),
        .in_ready     (in_ready),
        .stream_end   (stream_end),
        .win_we       (win_we),
        .win_sel      (win_sel),
        .win_wdata    (win_wdata),
        .tgt_ack      (tgt_ack),
        .xfer_busy    (xfer_busy),
        .done         (done),
        .err_partial  (err_partial)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [31:0] data;
        logic [7:0]  cmd;
    } rec_t;

    rec_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    int   we_count = 0;
    int   cmd_count = 0;
    int   busy_writes = 0;
    int   ack_delay = 2;
    bit   finished = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor / target model, sampled at the falling edge
    logic [7:0] shadow [7];
    int  next_sel = 0;
    bit  mid_prev = 1'b0;
    bit  order_bad = 1'b0;
    bit  pending = 1'b0;
    int  countdown = 0;
    bit  after_cmd = 1'b0;
    bit  after_ack = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            next_sel  = 0;
            mid_prev  = 1'b0;
            order_bad = 1'b0;
            pending   = 1'b0;
            after_cmd = 1'b0;
            after_ack = 1'b0;
            tgt_ack   <= 1'b0;
        end else begin
            if (after_cmd) begin
                chk("R4 busy after command", 64'(xfer_busy), 64'd1);
                after_cmd = 1'b0;
            end
            if (after_ack) begin
                chk("R4 busy clears after ack", 64'(xfer_busy), 64'd0);
                after_ack = 1'b0;
            end
            if (mid_prev && !win_we) order_bad = 1'b1;
            mid_prev = 1'b0;
            if (win_we) begin
                we_count++;
                if (xfer_busy) busy_writes++;
                if (int'(win_sel) != next_sel) order_bad = 1'b1;
                shadow[win_sel] = win_wdata;
                if (win_sel == 3'd6) begin
                    rec_t got;
                    rec_t want;
                    next_sel = 0;
                    cmd_count++;
                    got.data = {shadow[3], shadow[2], shadow[1], shadow[0]};
                    got.addr = {shadow[5], shadow[4]};
                    got.cmd  = shadow[6];
                    chk("R5 window order", 64'(order_bad), 64'd0);
                    order_bad = 1'b0;
                    if (exp_q.size() == 0) begin
                        chk("R3 unexpected command", 64'(got), 64'd0);
                    end else begin
                        want = exp_q.pop_front();
                        chk("R3 record contents", 64'(got), 64'(want));
                    end
                    pending   = 1'b1;
                    countdown = ack_delay;
                    after_cmd = 1'b1;
                end else begin
                    next_sel = int'(win_sel) + 1;
                    mid_prev = 1'b1;
                end
            end
            tgt_ack <= 1'b0;
            if (pending && xfer_busy) begin
                if (countdown == 0) begin
                    tgt_ack  <= 1'b1;
                    pending   = 1'b0;
                    after_ack = 1'b1;
                end else begin
                    countdown--;
                end
            end
        end
    end

    // driver tasks, called at the falling edge
    task automatic put_byte(input logic [7:0] b, input logic rgn);
        in_valid      = 1'b1;
        in_byte       = b;
        in_rec_region = rgn;
        if (rgn) begin
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid      = 1'b0;
        in_rec_region = 1'b0;
    endtask

    task automatic send_rec(input logic [15:0] a, input logic [31:0] d, input logic [7:0] c, input bit gaps);
        rec_t r;
        logic [7:0] seq [7];
        r.addr = a; r.data = d; r.cmd = c;
        exp_q.push_back(r);
        seq[0] = d[7:0];  seq[1] = d[15:8]; seq[2] = d[23:16]; seq[3] = d[31:24];
        seq[4] = a[7:0];  seq[5] = a[15:8]; seq[6] = c;
        for (int i = 0; i < 7; i++) begin
            put_byte(seq[i], 1'b1);
            if (gaps) begin
                put_byte(8'hA5 ^ 8'(i), 1'b0);
                in_byte = 8'h5A;
                in_rec_region = 1'b1;
                @(negedge clk);
                in_rec_region = 1'b0;
            end
        end
    endtask

    task automatic pulse_end();
        stream_end = 1'b1;
        @(negedge clk);
        stream_end = 1'b0;
    endtask

    task automatic wait_drained();
        for (int i = 0; i < 400; i++) begin
            if (exp_q.size() == 0 && !xfer_busy && !pending && !win_we) break;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int base_we;
        int base_cmd;
        do_reset();
        // R1
        chk("R1 win_we", 64'(win_we), 64'd0);
        chk("R1 xfer_busy", 64'(xfer_busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 err_partial", 64'(err_partial), 64'd0);
        chk("R1 in_ready", 64'(in_ready), 64'd1);

        // R3: example record 0C 00 18 10 00 00 01
        ack_delay = 2;
        send_rec(16'h0000, 32'h1018000C, 8'h01, 1'b0);
        wait_drained();
        chk("R3 example committed", 64'(cmd_count), 64'd1);

        // R2: bytes that are invalid or outside the record region
        base_we = we_count;
        for (int i = 0; i < 9; i++) put_byte(8'(i * 17), 1'b0);
        in_byte = 8'hEE; in_rec_region = 1'b1;
        repeat (4) @(negedge clk);
        in_rec_region = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 stray bytes cause no window write", 64'(we_count - base_we), 64'd0);
        send_rec(16'h0102, 32'hCAFEF00D, 8'h01, 1'b1);
        send_rec(16'hBEEF, 32'h00000001, 8'h01, 1'b1);
        wait_drained();

        // R6 / R7: long acknowledge, next record queued
        ack_delay = 30;
        send_rec(16'h0011, 32'h11223344, 8'h01, 1'b0);
        while (!xfer_busy) @(negedge clk);
        base_cmd = cmd_count;
        send_rec(16'h0022, 32'h55667788, 8'h01, 1'b0);
        @(negedge clk);
        chk("R7 in_ready low while record waits", 64'(in_ready), 64'd0);
        chk("R6 no write while busy", 64'(win_we), 64'd0);
        chk("R6 next record held", 64'(cmd_count - base_cmd), 64'd0);
        ack_delay = 4;
        send_rec(16'h3C00, 32'hFFFF0000, 8'h01, 1'b0);
        send_rec(16'h0040, 32'h89ABCDEF, 8'h01, 1'b0);

        // R9: end the stream while the tail is still in flight
        pulse_end();
        while (!xfer_busy) @(negedge clk);
        chk("R9 done low while busy", 64'(done), 64'd0);
        wait_drained();
        repeat (3) @(negedge clk);
        chk("R9 done after last ack", 64'(done), 64'd1);
        chk("R9 all records committed", 64'(cmd_count), 64'd7);
        chk("R8 no error on clean end", 64'(err_partial), 64'd0);
        chk("R6 writes during busy", 64'(busy_writes), 64'd0);

        // R10: bytes after end
        base_we = we_count;
        for (int i = 0; i < 8; i++) put_byte(8'h30 + 8'(i), 1'b1);
        repeat (15) @(negedge clk);
        chk("R10 bytes after end ignored", 64'(we_count - base_we), 64'd0);
        chk("R9 done stays high", 64'(done), 64'd1);

        // R8: truncated record
        do_reset();
        chk("R1 err clear after reset", 64'(err_partial), 64'd0);
        base_we = we_count;
        put_byte(8'h0C, 1'b1);
        put_byte(8'h00, 1'b1);
        put_byte(8'h18, 1'b1);
        pulse_end();
        repeat (12) @(negedge clk);
        chk("R8 err_partial set", 64'(err_partial), 64'd1);
        chk("R8 no window write for partial", 64'(we_count - base_we), 64'd0);
        chk("R9 done after partial drop", 64'(done), 64'd1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule